// File: doc/BRIEF.md
# SHA-512 Message Schedule Finisher

This block completes the SHA-512 message expansion for four new 64-bit schedule words in a single operation. It receives two 256-bit operands. Each operand is four 64-bit lanes, and lane 0 is the least significant. The first operand, `in_a`, carries partial sums that an earlier expansion stage has already built. The second operand, `in_b`, carries the most recent schedule words in its two upper lanes. The block adds the small-sigma-1 mix of a recent word to each partial sum. It returns the four finished words as one 256-bit result.

The upper half of the result depends on the lower half of the same result. The sigma input for lanes 2 and 3 is the just-finished word in lanes 0 and 1. This makes the datapath two adder levels deep in series. The parameter `MID_REG` can place a pipeline register between those two levels. Operands enter through a valid/ready handshake, and results leave through a registered valid/ready handshake. The block has no status outputs.

Top module: `sha512_sched_fin`

## Requirements
- R1: sigma1(x) is the XOR of x rotated right by 19, x rotated right by 61, and x shifted right logically by 6. Lane k of every 256-bit bus is bits [64k+63:64k].
- R2: Result lane 0 equals `in_a` lane 0 plus sigma1(`in_b` lane 2). Result lane 1 equals `in_a` lane 1 plus sigma1(`in_b` lane 3).
- R3: Result lane 2 equals `in_a` lane 2 plus sigma1(result lane 0). Result lane 3 equals `in_a` lane 3 plus sigma1(result lane 1).
- R4: Every addition wraps modulo 2^64. A carry out of bit 63 of one lane is discarded and never reaches the next lane.
- R5: Lanes 0 and 1 of `in_b` have no effect on the result.
- R6: An operation accepted at a clock edge (`in_valid` and `in_ready` both high) shows its result on `out_valid`/`out_data` exactly 1 + `MID_REG` edges later, provided `out_ready` stays high.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds its value into the next cycle.
- R8: `in_ready` is low only when `out_valid` is high and `out_ready` is low.
- R9: A synchronous active-high `rst` drives `out_valid` low at the next edge. While no result is pending, `in_ready` is high.
- R10: With `out_ready` held high, the block accepts one operation on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands presented |
| in_ready | output | 1 | Block can accept operands this cycle |
| in_a | input | 256 | Partial sums, four 64-bit lanes |
| in_b | input | 256 | Recent schedule words (lanes 2 and 3 used) |
| out_valid | output | 1 | Result presented |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 256 | Four finished schedule words |

## Verification
The assertions assume that the consumer's `out_ready` is a clean 0 or 1 on every cycle after reset. They also assume that operands are only changed or withdrawn away from an accepting edge, because a stage only samples data when its own handshake fires. The stimulus drives every input at the falling clock edge, so nothing changes near a rising edge. It then mixes back-to-back bursts, random gaps in `in_valid`, and random stalls on `out_ready`. These patterns exercise the hold and back-pressure behaviour, and all-zero and all-ones operands are included to hit the carry-wrap corners.

// File: rtl/sha512_sched_fin_pkg.sv
package sha512_sched_fin_pkg;

    parameter int WORD_W    = 64;
    parameter int NUM_LANES = 4;
    localparam int DATA_W   = WORD_W * NUM_LANES;
    localparam int HALF     = NUM_LANES / 2;

    // sigma1 constants
    parameter int ROT_FIRST  = 19;
    parameter int ROT_SECOND = 61;
    parameter int SHR_AMT    = 6;

    typedef logic [WORD_W-1:0] word_t;
    typedef word_t [NUM_LANES-1:0] vec_t;
    typedef word_t [HALF-1:0] half_t;

    // Carried between the two adder levels
    typedef struct packed {
        half_t a_upper;
        half_t lo_done;
    } mid_t;
    localparam int MID_W = $bits(mid_t);

    // Rotate right by a constant: pure wiring
    function automatic word_t rotr(input word_t x, input int n);
        int m;
        m = n % WORD_W;
        if (m == 0) return x;
        return (x >> m) | (x << (WORD_W - m));
    endfunction

    function automatic word_t sigma1(input word_t x);
        return rotr(x, ROT_FIRST) ^ rotr(x, ROT_SECOND) ^ (x >> SHR_AMT);
    endfunction

endpackage

// File: rtl/sha512_sched_lo.sv
// First adder level: result lanes 0 and 1 from operand A and B upper lanes.
module sha512_sched_lo
    import sha512_sched_fin_pkg::*;
(
    input  half_t a_lower,
    input  half_t b_upper,
    output half_t lo_done
);
    for (genvar i = 0; i < HALF; i++) begin : g_lane
        assign lo_done[i] = a_lower[i] + sigma1(b_upper[i]);
    end
endmodule

// File: rtl/sha512_sched_hi.sv
// Second adder level: result lanes 2 and 3 chained on lanes 0 and 1.
module sha512_sched_hi
    import sha512_sched_fin_pkg::*;
(
    input  half_t a_upper,
    input  half_t lo_done,
    output half_t hi_done
);
    for (genvar i = 0; i < HALF; i++) begin : g_lane
        assign hi_done[i] = a_upper[i] + sigma1(lo_done[i]);
    end
endmodule

// File: rtl/sha512_sched_stage.sv
// One valid/ready register stage; data is not reset.
module sha512_sched_stage #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         up_valid,
    output logic         up_ready,
    input  logic [W-1:0] up_data,
    output logic         dn_valid,
    input  logic         dn_ready,
    output logic [W-1:0] dn_data
);
    logic         vld_q;
    logic [W-1:0] dat_q;

    assign up_ready = !vld_q || dn_ready;
    assign dn_valid = vld_q;
    assign dn_data  = dat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
        end else if (up_ready) begin
            vld_q <= up_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (up_valid && up_ready) begin
            dat_q <= up_data;
        end
    end

    // R7
    stall_keeps_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (dn_valid && !dn_ready) |=> dn_valid);

    // R7
    stall_keeps_data_chk: assert property (@(posedge clk) disable iff (rst)
        (dn_valid && !dn_ready) |=> $stable(dn_data));

endmodule

// File: rtl/sha512_sched_fin.sv
module sha512_sched_fin
    import sha512_sched_fin_pkg::*;
#(
    parameter bit MID_REG = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data
);
    vec_t  a_v, b_v;
    half_t lo_now;
    mid_t  mid_in, mid_out;
    logic  mid_valid, mid_ready;
    half_t hi_now;
    vec_t  res_v;
    logic  b_lo_unused;

    assign a_v = in_a;
    assign b_v = in_b;
    assign b_lo_unused = ^b_v[HALF-1:0];   // R5: lower B lanes unused

    sha512_sched_lo u_lo (
        .a_lower (a_v[HALF-1:0]),
        .b_upper (b_v[NUM_LANES-1:HALF]),
        .lo_done (lo_now)
    );

    assign mid_in.a_upper = a_v[NUM_LANES-1:HALF];
    assign mid_in.lo_done = lo_now;

    if (MID_REG) begin : g_mid
        logic [MID_W-1:0] mid_q;
        sha512_sched_stage #(.W(MID_W)) u_mid (
            .clk      (clk),
            .rst      (rst),
            .up_valid (in_valid),
            .up_ready (in_ready),
            .up_data  (mid_in),
            .dn_valid (mid_valid),
            .dn_ready (mid_ready),
            .dn_data  (mid_q)
        );
        assign mid_out = mid_t'(mid_q);
    end else begin : g_flat
        assign mid_valid = in_valid;
        assign in_ready  = mid_ready;
        assign mid_out   = mid_in;
    end

    sha512_sched_hi u_hi (
        .a_upper (mid_out.a_upper),
        .lo_done (mid_out.lo_done),
        .hi_done (hi_now)
    );

    assign res_v[HALF-1:0]         = mid_out.lo_done;
    assign res_v[NUM_LANES-1:HALF] = hi_now;

    sha512_sched_stage #(.W(DATA_W)) u_out (
        .clk      (clk),
        .rst      (rst),
        .up_valid (mid_valid),
        .up_ready (mid_ready),
        .up_data  (res_v),
        .dn_valid (out_valid),
        .dn_ready (out_ready),
        .dn_data  (out_data)
    );

    // R8
    ready_low_only_on_stall_chk: assert property (@(posedge clk) disable iff (rst)
        !in_ready |-> (out_valid && !out_ready));

    // R9
    reset_clears_out_chk: assert property (@(posedge clk)
        rst |=> !out_valid);

    // R6
    if (MID_REG) begin : g_lat2
        accept_to_result_chk: assert property (@(posedge clk) disable iff (rst)
            (in_valid && in_ready) |=> ##1 out_valid);
    end else begin : g_lat1
        accept_to_result_chk: assert property (@(posedge clk) disable iff (rst)
            (in_valid && in_ready) |=> out_valid);
    end

endmodule

// File: tb/sha512_sched_fin_bench.sv
module sha512_sched_fin_bench;
    localparam int LAT = 1;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic         rst, in_valid, in_ready, out_valid, out_ready;
    logic [255:0] in_a, in_b, out_data;

    sha512_sched_fin u_sha512_sched_fin (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data)
    );

    int checks = 0, fails = 0, cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct { logic [255:0] exp; int t; bit timed; } ent_t;
    ent_t q[$];
    bit timed_phase = 0, ign_phase = 0, ign_have = 0;
    logic [255:0] ign_ref;
    bit prev_stall = 0;
    logic [255:0] prev_data;

    function automatic longint unsigned rr(longint unsigned x, int n);
        return (x >> n) | (x << (64 - n));
    endfunction
    function automatic longint unsigned s1(longint unsigned x);
        return rr(x, 19) ^ rr(x, 61) ^ (x >> 6);
    endfunction
    function automatic logic [255:0] model(logic [255:0] a, logic [255:0] b);
        longint unsigned w[4];
        w[0] = a[63:0]    + s1(b[191:128]);
        w[1] = a[127:64]  + s1(b[255:192]);
        w[2] = a[191:128] + s1(w[0]);
        w[3] = a[255:192] + s1(w[1]);
        return {w[3], w[2], w[1], w[0]};
    endfunction

    task automatic chk(bit ok, string req, logic [255:0] act, logic [255:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [255:0] rnd256();
        return {$urandom, $urandom, $urandom, $urandom,
                $urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic step(bit v, logic [255:0] a, logic [255:0] b, bit ordy);
        @(negedge clk);
        in_valid = v; in_a = a; in_b = b; out_ready = ordy;
        #1;
        if (prev_stall)
            chk(out_valid && out_data == prev_data, "R7 hold", out_data, prev_data);
        prev_stall = out_valid && !out_ready;
        prev_data  = out_data;
        if (!in_ready)
            chk(out_valid && !out_ready, "R8 backpressure", {255'd0, in_ready}, 256'd1);
        if (in_valid && in_ready)
            q.push_back('{model(a, b), cyc, timed_phase});
        if (out_valid && out_ready) begin
            if (q.size() == 0) begin
                chk(0, "R2 R3 spurious result", out_data, 256'd0);
            end else begin
                ent_t e = q.pop_front();
                chk(out_data == e.exp, "R1 R2 R3 R4 data", out_data, e.exp);
                if (e.timed)
                    chk(cyc == e.t + LAT, "R6 latency", 256'(cyc), 256'(e.t + LAT));
                if (ign_phase) begin
                    if (!ign_have) begin ign_ref = out_data; ign_have = 1; end
                    else chk(out_data == ign_ref, "R5 lower B ignored", out_data, ign_ref);
                end
            end
        end
    endtask

    task automatic drain();
        for (int i = 0; i < 20 && q.size() > 0; i++) step(0, '0, '0, 1);
        chk(q.size() == 0, "R6 drain", 256'(q.size()), 256'd0);
    endtask

    initial begin
        #4_000_000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [255:0] fa, fb;
        rst = 1; in_valid = 0; in_a = '0; in_b = '0; out_ready = 1;
        repeat (3) @(negedge clk);
        chk(!out_valid, "R9 reset valid", {255'd0, out_valid}, 256'd0);
        chk(in_ready, "R9 reset ready", {255'd0, in_ready}, 256'd1);
        @(negedge clk); rst = 0;

        // Corners: zeros, all ones, carry wrap (R4)
        timed_phase = 1;
        step(1, '0, '0, 1);
        step(1, '1, '1, 1);
        step(1, '1, '0, 1);
        step(1, {4{64'h8000_0000_0000_0000}}, {4{64'h0000_0000_0008_0000}}, 1);
        step(1, '0, '1, 1);
        drain();

        // Back-to-back throughput (R10)
        for (int i = 0; i < 200; i++) begin
            step(1, rnd256(), rnd256(), 1);
            chk(in_ready, "R10 one per cycle", {255'd0, in_ready}, 256'd1);
        end
        drain();
        timed_phase = 0;

        // Random gaps and stalls (R7 R8)
        for (int i = 0; i < 400; i++)
            step($urandom_range(0, 3) != 0, rnd256(), rnd256(), $urandom_range(0, 2) != 0);
        drain();

        // Lower B lanes varied with everything else fixed (R5)
        fa = rnd256(); fb = rnd256();
        ign_phase = 1;
        for (int i = 0; i < 20; i++)
            step(1, fa, {fb[255:128], rnd256() >> 128}, $urandom_range(0, 1) == 1);
        drain();
        ign_phase = 0;

        // Reset mid-stream (R9)
        step(1, rnd256(), rnd256(), 0);
        @(negedge clk); rst = 1; in_valid = 0;
        @(negedge clk); rst = 0;
        chk(!out_valid, "R9 reset flush", {255'd0, out_valid}, 256'd0);
        chk(in_ready, "R9 ready after reset", {255'd0, in_ready}, 256'd1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule